// File: doc/BRIEF.md
# Storage Transfer Pattern Generator and Checker

This block sources and sinks the 128-bit data stream of a storage controller test setup. In write mode it fills the controller's input FIFO with a known pattern. A one-cycle start pulse begins the transfer. Writes pause whenever the FIFO reports almost-full and stop once the programmed number of 512-byte blocks has gone out. In read mode it drains the controller's output FIFO whenever that FIFO holds data. It rebuilds the same pattern locally and compares every beat against it.

Every 512-byte block (32 beats) begins with a 64-bit header that holds the block index. The rest of the block carries the selected payload. The payload can be a dword counter, its inverse, a 31st-order LFSR stepped four times per beat, or a constant of all zeros or all ones. On the first mismatch the block keeps a record of the failure: the expected beat, the beat that was received and the byte address. A running byte count shows how far the transfer has progressed. Loading a new configuration rearms everything.

Top module: `stor_patt_gen`

## Requirements
- R1: After reset, wr_en_o, rd_en_o, wr_active_o and fail_o are 0, and cur_bytes_o and all capture outputs are 0.
- R2: A cycle with cfg_load_i high has these effects at the next edge:
  - it latches the block count, the direction (cfg_dir_rd_i: 1 = read), the verify enable and the pattern code;
  - it clears the beat counter, resets the LFSR to its seed, drops the write-active flag, and clears fail_o and every capture output.
- R3: Pattern codes 000, 001 and 100 put a header in the first beat of each block (beat index mod 32 = 0). Bits 63:0 of that beat hold the 64-bit block index, which is the beat index divided by 32, with its low dword in bits 31:0. All other dwords carry the payload.
- R4: Code 000 (increment) puts (4*b + k) mod 2^32 in dword lane k (bits 32k+31:32k) of beat b. Code 001 (decrement) puts the bitwise inverse of that value in the same lane.
- R5: Code 100 (LFSR) puts in lane k of beat b the state reached after 4*b + k steps from a seed of 32'h1. One step maps s to {s[30:0], s[30]^s[20]^s[0]}.
- R6: Code 010 makes every bit of every beat 0, with no header. Code 011 makes every bit 1, with no header. Codes 101 to 111 behave as 010.
- R7: A start_i pulse sets wr_active_o at the next edge, but only when the direction is write and the beats counted since the last load are below the block count times 32. Otherwise the pulse is ignored. wr_en_o is high exactly when wr_active_o is high and wr_afull_i is low.
- R8: wr_data_o carries the pattern beat for the current count in the same cycle that wr_en_o is high. Each write advances the count. The write that reaches the total clears wr_active_o, so wr_en_o stays low afterwards.
- R9: In read direction, rd_en_o equals the inverse of rd_empty_i in the same cycle. It is not gated by start_i or by the block count, and each read advances the count. In write direction rd_en_o is 0.
- R10: With verify enabled, a read beat that differs from the pattern does the following at the next edge:
  - it sets fail_o, which stays set until the next load;
  - it captures the expected beat, the received beat and the byte address (beat index * 16).
  Later mismatches leave the capture unchanged. With verify disabled, fail_o stays 0.
- R11: cur_bytes_o is the count of transferred beats times 16, 57 bits wide, and updates one edge after each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Latch configuration and clear state |
| cfg_blocks_i | input | 48 | Transfer size in 512-byte blocks |
| cfg_dir_rd_i | input | 1 | Direction: 1 read, 0 write |
| cfg_vfy_i | input | 1 | Enable read data comparison |
| cfg_patt_i | input | 3 | Pattern code |
| start_i | input | 1 | One-cycle write start pulse |
| wr_afull_i | input | 1 | Input FIFO almost-full |
| wr_en_o | output | 1 | Input FIFO write enable |
| wr_data_o | output | 128 | Input FIFO write data |
| rd_empty_i | input | 1 | Output FIFO empty |
| rd_en_o | output | 1 | Output FIFO read enable |
| rd_data_i | input | 128 | Output FIFO data (valid while not empty) |
| wr_active_o | output | 1 | Write transfer in progress |
| fail_o | output | 1 | Sticky verification failure |
| fail_exp_o | output | 128 | Expected beat of first failure |
| fail_rd_o | output | 128 | Received beat of first failure |
| fail_addr_o | output | 57 | Byte address of first failure |
| cur_bytes_o | output | 57 | Bytes transferred since load |

## Verification
The two FIFO enables are combinational, so they respond to almost-full or empty in the same cycle. wr_data_o is valid together with wr_en_o in that same cycle. wr_active_o, the byte count, fail_o and the capture fields each change one edge after the event that caused them. The bench therefore drives inputs 2 ns after a rising edge and samples at the following falling edge. It compares enables and write data at that falling edge. It reads counts and failure capture only after the edge that follows the last transfer or the mismatching beat.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned DW_BITS = 32;
  localparam int unsigned HDR_DW  = 2;
  localparam logic [31:0] LFSR_SEED = 32'h0000_0001;

  typedef enum logic [2:0] {
    PATT_INC  = 3'b000,
    PATT_DEC  = 3'b001,
    PATT_ZERO = 3'b010,
    PATT_ONE  = 3'b011,
    PATT_LFSR = 3'b100
  } patt_e;

  // x^31 + x^21 + x + 1
  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[30] ^ s[20] ^ s[0]};
  endfunction
endpackage

// File: rtl/pg_pattern.sv
module pg_pattern
  import pg_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = 53,
  parameter int unsigned BLK_LG = 5,
  localparam int unsigned DATA_W  = LANES * DW_BITS,
  localparam int unsigned LANE_LG = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              advance_i,
  input  logic [2:0]        patt_i,
  output logic [CNT_W-1:0]  beat_cnt_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CNT_W-1:0]  beat_cnt_q;
  logic [31:0]       lfsr_q;
  logic [31:0]       chain [LANES+1];
  logic [31:0]       dw_base;
  logic [DATA_W-1:0] hdr;
  logic              sof, hdr_mode;

  assign chain[0] = lfsr_q;
  for (genvar k = 0; k < LANES; k++) begin : g_step
    assign chain[k+1] = lfsr_step(chain[k]);
  end

  assign dw_base  = {beat_cnt_q[31-LANE_LG:0], LANE_LG'(0)};
  assign hdr      = DATA_W'(beat_cnt_q >> BLK_LG);
  assign sof      = (beat_cnt_q[BLK_LG-1:0] == '0);
  assign hdr_mode = (patt_i == PATT_INC) || (patt_i == PATT_DEC) || (patt_i == PATT_LFSR);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] inc_w, pat_w;
    assign inc_w = dw_base + 32'(k);
    always_comb begin
      case (patt_i)
        PATT_INC:  pat_w = inc_w;
        PATT_DEC:  pat_w = ~inc_w;
        PATT_ONE:  pat_w = '1;
        PATT_LFSR: pat_w = chain[k];
        default:   pat_w = '0;
      endcase
      if ((k < HDR_DW) && sof && hdr_mode) pat_w = hdr[k*DW_BITS +: DW_BITS];
    end
    assign data_o[k*DW_BITS +: DW_BITS] = pat_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_cnt_q <= '0;
      lfsr_q     <= LFSR_SEED;
    end else if (clear_i) begin
      beat_cnt_q <= '0;
      lfsr_q     <= LFSR_SEED;
    end else if (advance_i) begin
      beat_cnt_q <= beat_cnt_q + CNT_W'(1);
      lfsr_q     <= chain[LANES];
    end
  end

  assign beat_cnt_o = beat_cnt_q;

  a_r11_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !clear_i) |=> (beat_cnt_q == $past(beat_cnt_q) + CNT_W'(1)));
  a_r2_clear_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (beat_cnt_q == '0 && lfsr_q == LFSR_SEED));
endmodule

// File: rtl/pg_wr_ctrl.sv
module pg_wr_ctrl #(
  parameter int unsigned CNT_W = 53
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             dir_rd_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             afull_i,
  input  logic [CNT_W-1:0] beat_cnt_i,
  output logic             wr_en_o,
  output logic             active_o
);
  logic active_q, last_beat;

  assign last_beat = (beat_cnt_i + CNT_W'(1) == total_i);
  assign wr_en_o   = active_q & ~afull_i;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            active_q <= 1'b0;
    else if (clear_i)                                       active_q <= 1'b0;
    else if (wr_en_o && last_beat)                          active_q <= 1'b0;
    else if (start_i && !dir_rd_i && beat_cnt_i < total_i)  active_q <= 1'b1;
  end

  a_r7_start_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(start_i));
  a_r8_stop_at_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && last_beat && !clear_i) |=> !active_q);
endmodule

// File: rtl/pg_rd_check.sv
module pg_rd_check #(
  parameter int unsigned CNT_W   = 53,
  parameter int unsigned DATA_W  = 128,
  parameter int unsigned BYTE_LG = 4,
  localparam int unsigned ADDR_W = CNT_W + BYTE_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              dir_rd_i,
  input  logic              vfy_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [CNT_W-1:0]  beat_cnt_i,
  output logic              rd_en_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_rd_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  logic              fail_q, mism;
  logic [DATA_W-1:0] exp_q, rd_q;
  logic [ADDR_W-1:0] addr_q;

  assign rd_en_o = dir_rd_i & ~empty_i;
  assign mism    = rd_en_o & vfy_i & (rd_data_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0; exp_q <= '0; rd_q <= '0; addr_q <= '0;
    end else if (clear_i) begin
      fail_q <= 1'b0; exp_q <= '0; rd_q <= '0; addr_q <= '0;
    end else if (mism && !fail_q) begin
      fail_q <= 1'b1;
      exp_q  <= exp_i;
      rd_q   <= rd_data_i;
      addr_q <= {beat_cnt_i, BYTE_LG'(0)};
    end
  end

  assign fail_o      = fail_q;
  assign fail_exp_o  = exp_q;
  assign fail_rd_o   = rd_q;
  assign fail_addr_o = addr_q;

  a_r10_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clear_i) |=> fail_q);
  a_r10_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clear_i) |=> ($stable(addr_q) && $stable(rd_q) && $stable(exp_q)));
  a_r10_no_vfy_no_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_q && !vfy_i) |=> !fail_q);
endmodule

// File: rtl/stor_patt_gen.sv
module stor_patt_gen
  import pg_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned BLK_W     = 48,
  parameter int unsigned BLK_BYTES = 512,
  localparam int unsigned DATA_W  = LANES * DW_BITS,
  localparam int unsigned BYTE_LG = $clog2(DATA_W / 8),
  localparam int unsigned BLK_LG  = $clog2(BLK_BYTES / (DATA_W / 8)),
  localparam int unsigned CNT_W   = BLK_W + BLK_LG,
  localparam int unsigned ADDR_W  = CNT_W + BYTE_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [BLK_W-1:0]  cfg_blocks_i,
  input  logic              cfg_dir_rd_i,
  input  logic              cfg_vfy_i,
  input  logic [2:0]        cfg_patt_i,
  input  logic              start_i,
  input  logic              wr_afull_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              rd_empty_i,
  output logic              rd_en_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_active_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_rd_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ADDR_W-1:0] cur_bytes_o
);
  logic [BLK_W-1:0]  blocks_q;
  logic              dir_rd_q, vfy_q;
  logic [2:0]        patt_q;
  logic [CNT_W-1:0]  beat_cnt, total;
  logic [DATA_W-1:0] patt_data;
  logic              advance;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blocks_q <= '0; dir_rd_q <= 1'b0; vfy_q <= 1'b0; patt_q <= PATT_INC;
    end else if (cfg_load_i) begin
      blocks_q <= cfg_blocks_i;
      dir_rd_q <= cfg_dir_rd_i;
      vfy_q    <= cfg_vfy_i;
      patt_q   <= cfg_patt_i;
    end
  end

  assign total   = {blocks_q, BLK_LG'(0)};
  assign advance = wr_en_o | rd_en_o;

  pg_pattern #(.LANES(LANES), .CNT_W(CNT_W), .BLK_LG(BLK_LG)) i_pattern (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cfg_load_i),
    .advance_i  (advance),
    .patt_i     (patt_q),
    .beat_cnt_o (beat_cnt),
    .data_o     (patt_data)
  );

  pg_wr_ctrl #(.CNT_W(CNT_W)) i_wr_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cfg_load_i),
    .start_i    (start_i),
    .dir_rd_i   (dir_rd_q),
    .total_i    (total),
    .afull_i    (wr_afull_i),
    .beat_cnt_i (beat_cnt),
    .wr_en_o    (wr_en_o),
    .active_o   (wr_active_o)
  );

  pg_rd_check #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BYTE_LG(BYTE_LG)) i_rd_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (cfg_load_i),
    .dir_rd_i    (dir_rd_q),
    .vfy_i       (vfy_q),
    .empty_i     (rd_empty_i),
    .rd_data_i   (rd_data_i),
    .exp_i       (patt_data),
    .beat_cnt_i  (beat_cnt),
    .rd_en_o     (rd_en_o),
    .fail_o      (fail_o),
    .fail_exp_o  (fail_exp_o),
    .fail_rd_o   (fail_rd_o),
    .fail_addr_o (fail_addr_o)
  );

  assign wr_data_o   = patt_data;
  assign cur_bytes_o = {beat_cnt, BYTE_LG'(0)};

  a_r9_dir_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && rd_en_o));
  a_r7_no_write_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_rd_q |-> !wr_active_o);
endmodule

// File: tb/test_stor_patt_gen.sv
module test_stor_patt_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [47:0]  cfg_blocks = '0;
  logic         cfg_dir_rd = 1'b0, cfg_vfy = 1'b0;
  logic [2:0]   cfg_patt = '0;
  logic         start = 1'b0, wr_afull = 1'b0, rd_empty = 1'b1;
  logic [127:0] rd_data = '0;
  logic         wr_en, rd_en, wr_active, fail;
  logic [127:0] wr_data, fail_exp, fail_rd;
  logic [56:0]  fail_addr, cur_bytes;

  int n_chk = 0, n_err = 0;
  logic [127:0] sb_q[$];
  string mon_tag = "R8";

  always #4 clk = ~clk;

  stor_patt_gen i_stor_patt_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_blocks_i(cfg_blocks),
    .cfg_dir_rd_i(cfg_dir_rd), .cfg_vfy_i(cfg_vfy), .cfg_patt_i(cfg_patt),
    .start_i(start), .wr_afull_i(wr_afull), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .rd_empty_i(rd_empty), .rd_en_o(rd_en), .rd_data_i(rd_data),
    .wr_active_o(wr_active), .fail_o(fail), .fail_exp_o(fail_exp),
    .fail_rd_o(fail_rd), .fail_addr_o(fail_addr), .cur_bytes_o(cur_bytes));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bstep(input logic [31:0] s);
    return {s[30:0], s[30] ^ s[20] ^ s[0]};
  endfunction

  function automatic logic [127:0] model(input int b, input logic [2:0] p);
    logic [127:0] r;
    logic [31:0] s, v, dw;
    for (int k = 0; k < 4; k++) begin
      dw = 32'(4*b + k);
      case (p)
        3'b000: v = dw;
        3'b001: v = ~dw;
        3'b011: v = '1;
        3'b100: begin
          s = 32'h1;
          for (int i = 0; i < 4*b + k; i++) s = bstep(s);
          v = s;
        end
        default: v = '0;
      endcase
      if ((p == 3'b000 || p == 3'b001 || p == 3'b100) && (b % 32 == 0) && k < 2)
        v = (k == 0) ? 32'(b / 32) : 32'h0;
      r[k*32 +: 32] = v;
    end
    return r;
  endfunction

  // scoreboard monitor for the write stream
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      chk(!wr_afull, "R7", "write while almost full", 128'(wr_afull), 128'(0));
      if (sb_q.size() == 0) chk(1'b0, "R8", "write beyond total", wr_data, '0);
      else begin
        logic [127:0] e;
        e = sb_q.pop_front();
        chk(wr_data === e, mon_tag, "write beat", wr_data, e);
      end
    end
  end

  task automatic load(input int blocks, input bit dir_rd, input bit vfy, input logic [2:0] p);
    @(posedge clk); #2;
    cfg_blocks = 48'(blocks); cfg_dir_rd = dir_rd; cfg_vfy = vfy; cfg_patt = p; cfg_load = 1'b1;
    @(posedge clk); #2;
    cfg_load = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  // mode 0: no back-pressure, 1: periodic almost-full, 2: held full after start
  task automatic run_write(input logic [2:0] p, input int blocks, input int mode, input string tag);
    load(blocks, 1'b0, 1'b0, p);
    mon_tag = tag;
    for (int b = 0; b < blocks*32; b++) sb_q.push_back(model(b, p));
    wr_afull = (mode == 2);
    pulse_start();
    if (mode == 2) begin
      repeat (4) begin
        @(negedge clk);
        chk(!wr_en && wr_active, "R7", "held by almost full", {wr_en, wr_active}, 2'b01);
      end
      chk(cur_bytes == 0, "R11", "no bytes while held", 128'(cur_bytes), 0);
    end
    for (int c = 0; c < 4000 && sb_q.size() != 0; c++) begin
      @(posedge clk); #2;
      wr_afull = (mode == 1) ? (c % 3 == 1) : 1'b0;
    end
    wr_afull = 1'b0;
    chk(sb_q.size() == 0, "R8", "all beats written", 128'(sb_q.size()), 0);
    repeat (3) begin
      @(negedge clk);
      chk(!wr_en && !wr_active, "R8", "stop at total", {wr_en, wr_active}, 0);
    end
    chk(cur_bytes == 57'(blocks*512), "R11", "byte count after write",
        128'(cur_bytes), 128'(blocks*512));
    sb_q.delete();
  endtask

  task automatic run_read(input logic [2:0] p, input int blocks, input int n, input bit vfy,
                          input int e1, input int e2);
    int idx = 0;
    load(blocks, 1'b1, vfy, p);
    for (int c = 0; c < 4000 && idx < n; c++) begin
      @(posedge clk); #2;
      rd_empty = (c % 4 == 3);
      rd_data  = model(idx, p) ^ ((idx == e1 || idx == e2) ? 128'h1 << (idx % 128) : 128'h0);
      @(negedge clk);
      chk(rd_en == !rd_empty, "R9", "read follows not-empty", 128'(rd_en), 128'(!rd_empty));
      chk(!wr_en, "R9", "no write in read", 128'(wr_en), 0);
      if (rd_en) idx++;
    end
    @(posedge clk); #2 rd_empty = 1'b1;
    @(negedge clk);
    chk(cur_bytes == 57'(n*16), "R11", "byte count after read", 128'(cur_bytes), 128'(n*16));
  endtask

  initial begin
    #(8*150000);
    chk(1'b0, "R1", "watchdog expired", 0, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] e;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !rd_en && !wr_active && !fail, "R1", "enables after reset",
        {wr_en, rd_en, wr_active, fail}, 0);
    chk(cur_bytes == 0 && fail_addr == 0 && fail_exp == 0 && fail_rd == 0, "R1",
        "counts after reset", 128'(cur_bytes), 0);

    run_write(3'b000, 2, 1, "R3 R4 inc");
    run_write(3'b001, 1, 0, "R3 R4 dec");
    run_write(3'b100, 2, 1, "R5 lfsr");
    run_write(3'b010, 1, 0, "R6 zero");
    run_write(3'b011, 1, 2, "R6 one");
    run_write(3'b110, 1, 0, "R6 reserved");

    // restart without reload: total already reached
    pulse_start();
    repeat (3) begin
      @(negedge clk);
      chk(!wr_en && !wr_active, "R7", "start after total", {wr_en, wr_active}, 0);
    end

    // zero-block transfer
    load(0, 1'b0, 1'b0, 3'b000);
    pulse_start();
    repeat (3) begin
      @(negedge clk);
      chk(!wr_en && !wr_active, "R7", "start with zero total", {wr_en, wr_active}, 0);
    end

    // start in read direction, FIFO empty
    load(2, 1'b1, 1'b1, 3'b000);
    pulse_start();
    repeat (3) begin
      @(negedge clk);
      chk(!wr_en && !wr_active && !rd_en, "R7", "start in read dir",
          {wr_en, wr_active, rd_en}, 0);
    end

    // read past the total with two corrupted beats
    run_read(3'b000, 1, 48, 1'b1, 37, 45);
    e = model(37, 3'b000);
    chk(fail, "R10", "fail set", 128'(fail), 1);
    chk(fail_addr == 57'(37*16), "R10", "fail address", 128'(fail_addr), 128'(37*16));
    chk(fail_exp == e, "R10", "fail expected beat", fail_exp, e);
    chk(fail_rd == (e ^ (128'h1 << 37)), "R10", "fail read beat", fail_rd, e ^ (128'h1 << 37));

    // reload clears capture and count
    load(1, 1'b1, 1'b1, 3'b100);
    @(negedge clk);
    chk(!fail && fail_addr == 0 && fail_exp == 0 && fail_rd == 0, "R2", "load clears capture",
        {fail, 71'(fail_addr)}, 0);
    chk(cur_bytes == 0, "R2", "load clears count", 128'(cur_bytes), 0);

    run_read(3'b100, 1, 40, 1'b1, -1, -1);
    chk(!fail, "R5", "clean lfsr read", 128'(fail), 0);

    run_read(3'b001, 1, 32, 1'b1, 0, -1);
    chk(fail && fail_addr == 0, "R3", "header mismatch at beat 0", 128'(fail_addr), 0);

    run_read(3'b000, 1, 20, 1'b0, 3, 5);
    chk(!fail && fail_addr == 0, "R10", "verify off ignores mismatch", 128'(fail), 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule